// File: doc/BRIEF.md
# Power-On Supervisor with Output Gating

This block decides when a monitoring chip may run its transmitter outputs, based on how healthy the supply is. Two comparator flags come in. One says the supply is above a brown-out level. The other says it is above a higher analog-ready level.

- Losing only the analog-ready level suspends the part. The outputs are switched off, and they return at once when the level comes back.
- Losing the brown-out level wipes the working registers. A fresh nonvolatile settings recall is then required.
- The recall is a single-cycle request, answered by a done acknowledge.
- After the acknowledge, a settle timer counts a fixed 500 µs at the system clock. Only then does the active-low ready status fall.

The block also picks the serial-bus slave address. The address stays at A2h until a recall has completed. After that it may switch to the recalled value.

A supply-low alarm is raised at power-up and whenever the supply is below analog-ready. It clears only when an ADC supply conversion lies above a programmable limit.

In the running state, the transmit-disable pin and a fault input drive three outputs:
- the modulation/bias enable;
- a fault-gate pin, whose alarm polarity is set by a direction bit;
- a fault flag.

While the supply-low alarm is set, faults are not latched.

Top module: `psup_top`

## Requirements
- R1: While the supply is not in the running state (below analog-ready, recall or settle pending), `drive_en` is 0, `rdy_n` is 1 and `fault_flag` is 1; the state falls out of running on the first clock edge that samples `ana_ok` low.
- R2: The fault-gate alarm level equals `gate_dir` and its non-alarm level is the complement; whenever `rdy_n` is 1, `fault_gate` is at the alarm level.
- R3: If `ana_ok` drops and returns while `bor_ok` stays 1 after a completed recall, `rdy_n` returns to 0 on the first edge that samples `ana_ok` high again, and no recall request is issued.
- R4: Sampling `bor_ok` low returns the address shadow to its default and forgets the completed recall, so the next rise of `ana_ok` issues a new request.
- R5: `recall_req` is high for exactly one cycle, set by the edge that first samples `ana_ok` high while no recall has completed since the last brown-out.
- R6: `rdy_n` falls exactly SETTLE_CYCLES = CLK_MHZ·SETTLE_US edges after the edge that samples `recall_done` high.
- R7: `slave_addr` is A2h until a recall completes; afterwards it is the `nv_addr` value captured with `recall_done` if `nv_addr_sel` was 1 then, else A2h.
- R8: `vcc_low_alarm` is 1 after reset and whenever `ana_ok` or `bor_ok` is sampled low; it clears on the edge that samples `adc_valid` with `adc_code` strictly greater than `low_limit`, and a code equal to the limit leaves it set.
- R9: While `vcc_low_alarm` is 1 in the running state, `fault_in` is not latched: `fault_flag` stays 0 and `drive_en` stays 1 with `tx_off` low.
- R10: In the running state with the alarm clear:
  - with `tx_off` high: `drive_en`=0, `fault_gate`=~`gate_dir` and `fault_flag`=0, and any latched fault is cleared;
  - with `tx_off` low and no latched fault: `drive_en`=1, `fault_gate`=~`gate_dir` and `fault_flag`=0;
  - a `fault_in` high is latched on the next edge, giving `drive_en`=0, `fault_gate`=`gate_dir` and `fault_flag`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bor_ok | input | 1 | Supply above brown-out level |
| ana_ok | input | 1 | Supply above analog-ready level |
| tx_off | input | 1 | Transmit-disable pin |
| fault_in | input | 1 | Unmasked fault source |
| gate_dir | input | 1 | Alarm polarity of fault-gate output |
| adc_valid | input | 1 | Supply conversion strobe |
| adc_code | input | ADC_W | Supply conversion result |
| low_limit | input | ADC_W | Programmable supply-low limit |
| nv_addr | input | 8 | Recalled slave address |
| nv_addr_sel | input | 1 | Recalled address-source select |
| recall_done | input | 1 | Recall acknowledge |
| recall_req | output | 1 | Recall request pulse |
| rdy_n | output | 1 | Active-low ready status |
| slave_addr | output | 8 | Serial-bus slave address |
| drive_en | output | 1 | Modulation/bias enable |
| fault_gate | output | 1 | Fault-gate pin level |
| fault_flag | output | 1 | Transmit fault flag |
| vcc_low_alarm | output | 1 | Supply-low alarm |

## Verification
The assertions assume that `recall_done` arrives only while a request is outstanding. They also assume that `bor_ok` is never low while `ana_ok` is high, because the two flags come from nested thresholds. The stimulus keeps to both assumptions: it always lowers `ana_ok` together with or before `bor_ok`, and it pulses `recall_done` for one cycle after each observed request. ADC conversions are given only while `ana_ok` is high, which matches an ADC that cannot measure below the analog-ready level.

// File: rtl/psup_pkg.sv
package psup_pkg;

    typedef enum logic [1:0] {
        PS_WAIT,
        PS_RECALL,
        PS_SETTLE,
        PS_RUN
    } pstate_e;

    localparam logic [7:0] DEFAULT_ADDR = 8'hA2;

    typedef struct packed {
        logic tx_off;
        logic fault;
        logic dir;
    } gate_in_t;

    typedef struct packed {
        logic drive_en;
        logic fault_gate;
        logic fault_flag;
    } gate_out_t;

    // Pin level of the fault gate: the direction bit when alarmed, else its inverse.
    function automatic logic gate_level(input logic alarm, input logic dir);
        return alarm ? dir : ~dir;
    endfunction

endpackage

// File: rtl/psup_seq.sv
module psup_seq
    import psup_pkg::*;
#(
    parameter int SETTLE_CYCLES = 100000
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    bor_ok,
    input  logic    ana_ok,
    input  logic    recall_done,
    output pstate_e state,
    output logic    recall_req,
    output logic    cap_stb
);
    localparam int CW = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

    logic          recalled;
    logic [CW-1:0] cnt;

    assign cap_stb = (state == PS_RECALL) && ana_ok && recall_done;

    always_ff @(posedge clk) begin
        if (rst || !bor_ok) begin
            state      <= PS_WAIT;
            recalled   <= 1'b0;
            recall_req <= 1'b0;
            cnt        <= '0;
        end else begin
            recall_req <= 1'b0;
            unique case (state)
                PS_WAIT: begin
                    if (ana_ok) begin
                        if (recalled) begin
                            state <= PS_RUN;
                        end else begin
                            state      <= PS_RECALL;
                            recall_req <= 1'b1;
                        end
                    end
                end
                PS_RECALL: begin
                    if (!ana_ok) begin
                        state <= PS_WAIT;
                    end else if (recall_done) begin
                        state    <= PS_SETTLE;
                        recalled <= 1'b1;
                        cnt      <= '0;
                    end
                end
                PS_SETTLE: begin
                    if (!ana_ok) begin
                        state <= PS_WAIT;
                    end else if (cnt == LAST) begin
                        state <= PS_RUN;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PS_RUN: begin
                    if (!ana_ok) state <= PS_WAIT;
                end
                default: state <= PS_WAIT;
            endcase
        end
    end
endmodule

// File: rtl/psup_addr.sv
module psup_addr
    import psup_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bor_ok,
    input  logic       cap_stb,
    input  logic [7:0] nv_addr,
    input  logic       nv_addr_sel,
    output logic [7:0] slave_addr
);
    logic [7:0] addr_q;
    logic       use_nv;

    always_ff @(posedge clk) begin
        if (rst || !bor_ok) begin
            addr_q <= DEFAULT_ADDR;
            use_nv <= 1'b0;
        end else if (cap_stb) begin
            addr_q <= nv_addr;
            use_nv <= nv_addr_sel;
        end
    end

    assign slave_addr = use_nv ? addr_q : DEFAULT_ADDR;
endmodule

// File: rtl/psup_gate.sv
module psup_gate
    import psup_pkg::*;
#(
    parameter int ADC_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             bor_ok,
    input  logic             ana_ok,
    input  logic             adc_valid,
    input  logic [ADC_W-1:0] adc_code,
    input  logic [ADC_W-1:0] low_limit,
    input  gate_in_t         gin,
    output gate_out_t        gout,
    output logic             vcc_low_alarm
);
    logic latched;
    logic alarm_now;

    always_ff @(posedge clk) begin
        if (rst || !bor_ok || !ana_ok) begin
            vcc_low_alarm <= 1'b1;
        end else if (adc_valid && (adc_code > low_limit)) begin
            vcc_low_alarm <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run || gin.tx_off) begin
            latched <= 1'b0;
        end else if (gin.fault && !vcc_low_alarm) begin
            latched <= 1'b1;
        end
    end

    always_comb begin
        alarm_now       = !run || (latched && !gin.tx_off);
        gout.drive_en   = run && !gin.tx_off && !latched;
        gout.fault_gate = gate_level(alarm_now, gin.dir);
        gout.fault_flag = !run || (latched && !gin.tx_off);
    end
endmodule

// File: rtl/psup_top.sv
module psup_top
    import psup_pkg::*;
#(
    parameter int ADC_W     = 10,
    parameter int CLK_MHZ   = 200,
    parameter int SETTLE_US = 500
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bor_ok,
    input  logic             ana_ok,
    input  logic             tx_off,
    input  logic             fault_in,
    input  logic             gate_dir,
    input  logic             adc_valid,
    input  logic [ADC_W-1:0] adc_code,
    input  logic [ADC_W-1:0] low_limit,
    input  logic [7:0]       nv_addr,
    input  logic             nv_addr_sel,
    input  logic             recall_done,
    output logic             recall_req,
    output logic             rdy_n,
    output logic [7:0]       slave_addr,
    output logic             drive_en,
    output logic             fault_gate,
    output logic             fault_flag,
    output logic             vcc_low_alarm
);
    localparam int SETTLE_CYCLES = CLK_MHZ * SETTLE_US;

    pstate_e   state;
    logic      cap_stb;
    gate_in_t  gin;
    gate_out_t gout;

    psup_seq #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_seq (
        .clk(clk), .rst(rst), .bor_ok(bor_ok), .ana_ok(ana_ok),
        .recall_done(recall_done), .state(state),
        .recall_req(recall_req), .cap_stb(cap_stb)
    );

    psup_addr u_addr (
        .clk(clk), .rst(rst), .bor_ok(bor_ok), .cap_stb(cap_stb),
        .nv_addr(nv_addr), .nv_addr_sel(nv_addr_sel), .slave_addr(slave_addr)
    );

    assign gin = '{tx_off: tx_off, fault: fault_in, dir: gate_dir};

    psup_gate #(.ADC_W(ADC_W)) u_gate (
        .clk(clk), .rst(rst), .run(state == PS_RUN), .bor_ok(bor_ok),
        .ana_ok(ana_ok), .adc_valid(adc_valid), .adc_code(adc_code),
        .low_limit(low_limit), .gin(gin), .gout(gout),
        .vcc_low_alarm(vcc_low_alarm)
    );

    assign rdy_n      = (state != PS_RUN);
    assign drive_en   = gout.drive_en;
    assign fault_gate = gout.fault_gate;
    assign fault_flag = gout.fault_flag;
endmodule

// File: rtl/psup_chk.sv
module psup_chk #(
    parameter int ADC_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             bor_ok,
    input logic             ana_ok,
    input logic             adc_valid,
    input logic [ADC_W-1:0] adc_code,
    input logic [ADC_W-1:0] low_limit,
    input logic             gate_dir,
    input logic             recall_req,
    input logic             rdy_n,
    input logic             drive_en,
    input logic             fault_gate,
    input logic             fault_flag,
    input logic             vcc_low_alarm
);
    assert_outputs_off_R1: assert property (@(posedge clk) disable iff (rst)
        rdy_n |-> (!drive_en && fault_flag));

    assert_drop_suspends_R1: assert property (@(posedge clk) disable iff (rst)
        !ana_ok |=> rdy_n);

    assert_gate_alarm_level_R2: assert property (@(posedge clk) disable iff (rst)
        rdy_n |-> (fault_gate == gate_dir));

    assert_req_single_R5: assert property (@(posedge clk) disable iff (rst)
        recall_req |=> !recall_req);

    assert_alarm_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (bor_ok && ana_ok && adc_valid && (adc_code > low_limit)) |=> !vcc_low_alarm);

    assert_alarm_set_R8: assert property (@(posedge clk) disable iff (rst)
        !ana_ok |=> vcc_low_alarm);

    assert_no_latch_R9: assert property (@(posedge clk) disable iff (rst)
        (!rdy_n && vcc_low_alarm) |-> !fault_flag);
endmodule

bind psup_top psup_chk #(.ADC_W(ADC_W)) u_chk (.*);

// File: tb/psup_top_tb_top.sv
`timescale 1ns/1ps
module psup_top_tb_top;
    localparam int ADC_W = 10;
    localparam int N     = 10; // CLK_MHZ=1 * SETTLE_US=10

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bor_ok = 1'b0, ana_ok = 1'b0, tx_off = 1'b0, fault_in = 1'b0, gate_dir = 1'b0;
    logic adc_valid = 1'b0;
    logic [ADC_W-1:0] adc_code = '0;
    logic [ADC_W-1:0] low_limit = 10'd300;
    logic [7:0] nv_addr = 8'h00;
    logic nv_addr_sel = 1'b0, recall_done = 1'b0;
    logic recall_req, rdy_n, drive_en, fault_gate, fault_flag, vcc_low_alarm;
    logic [7:0] slave_addr;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;

    psup_top #(.ADC_W(ADC_W), .CLK_MHZ(1), .SETTLE_US(10)) dut_i (
        .clk(clk), .rst(rst), .bor_ok(bor_ok), .ana_ok(ana_ok), .tx_off(tx_off),
        .fault_in(fault_in), .gate_dir(gate_dir), .adc_valid(adc_valid),
        .adc_code(adc_code), .low_limit(low_limit), .nv_addr(nv_addr),
        .nv_addr_sel(nv_addr_sel), .recall_done(recall_done),
        .recall_req(recall_req), .rdy_n(rdy_n), .slave_addr(slave_addr),
        .drive_en(drive_en), .fault_gate(fault_gate), .fault_flag(fault_flag),
        .vcc_low_alarm(vcc_low_alarm)
    );

    // {tx_off, fault, dir, exp drive_en, exp fault_gate, exp fault_flag}
    localparam logic [5:0] VEC [8] = '{
        6'b000_110, 6'b001_100, 6'b010_001, 6'b011_011,
        6'b100_010, 6'b101_000, 6'b110_010, 6'b111_000
    };

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            finish_run();
        end
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        // R1/R2/R7/R8: reset state
        check("R1 rdy_n", rdy_n, 1);
        check("R1 drive_en", drive_en, 0);
        check("R1 fault_flag", fault_flag, 1);
        check("R2 fault_gate alarm", fault_gate, 0);
        gate_dir = 1'b1;
        #0.5;
        check("R2 fault_gate follows dir", fault_gate, 1);
        check("R7 default addr", slave_addr, 8'hA2);
        check("R8 alarm at reset", vcc_low_alarm, 1);
        check("R5 no req at reset", recall_req, 0);

        // R5: power-up issues one request
        nv_addr = 8'h5C; nv_addr_sel = 1'b1;
        bor_ok = 1'b1; ana_ok = 1'b1;
        step(1);
        check("R5 req raised", recall_req, 1);
        step(1);
        check("R5 req single cycle", recall_req, 0);
        check("R7 addr before recall", slave_addr, 8'hA2);

        // R6: settle timing
        recall_done = 1'b1;
        step(1);
        recall_done = 1'b0;
        check("R7 addr after recall", slave_addr, 8'h5C);
        step(N - 1);
        check("R6 still settling", rdy_n, 1);
        step(1);
        check("R6 ready", rdy_n, 0);

        // R9: alarm still set, faults ignored
        fault_in = 1'b1;
        step(2);
        check("R9 flag held", fault_flag, 0);
        check("R9 drive kept", drive_en, 1);
        fault_in = 1'b0;

        // R8: equal code keeps alarm, greater clears
        adc_valid = 1'b1; adc_code = 10'd300;
        step(1);
        check("R8 equal keeps alarm", vcc_low_alarm, 1);
        adc_code = 10'd301;
        step(1);
        adc_valid = 1'b0;
        check("R8 above clears alarm", vcc_low_alarm, 0);

        // R10: output table
        for (int v = 0; v < 8; v++) begin
            tx_off = 1'b1; fault_in = 1'b0;
            step(1);
            {tx_off, fault_in, gate_dir} = VEC[v][5:3];
            step(2);
            check($sformatf("R10 drive_en v%0d", v), drive_en, VEC[v][2]);
            check($sformatf("R10 fault_gate v%0d", v), fault_gate, VEC[v][1]);
            check($sformatf("R10 fault_flag v%0d", v), fault_flag, VEC[v][0]);
        end
        // R10: tx_off clears a latched fault
        tx_off = 1'b0; fault_in = 1'b1; gate_dir = 1'b0;
        step(2);
        fault_in = 1'b0;
        step(1);
        check("R10 fault held latched", fault_flag, 1);
        tx_off = 1'b1;
        step(1);
        tx_off = 1'b0;
        step(1);
        check("R10 latch cleared by tx_off", drive_en, 1);

        // R1/R3: suspend and resume without recall
        ana_ok = 1'b0;
        step(1);
        check("R1 suspended rdy_n", rdy_n, 1);
        check("R1 suspended drive", drive_en, 0);
        check("R2 suspended gate", fault_gate, 0);
        check("R8 alarm re-set", vcc_low_alarm, 1);
        ana_ok = 1'b1;
        step(1);
        check("R3 immediate resume", rdy_n, 0);
        check("R3 no new req", recall_req, 0);
        check("R3 addr kept", slave_addr, 8'h5C);

        // R4: brown-out wipes and requires new recall
        ana_ok = 1'b0; bor_ok = 1'b0;
        step(1);
        check("R4 addr default", slave_addr, 8'hA2);
        bor_ok = 1'b1;
        step(2);
        check("R4 no req while low", recall_req, 0);
        nv_addr_sel = 1'b0;
        ana_ok = 1'b1;
        step(1);
        check("R4 new req", recall_req, 1);
        check("R4 not ready", rdy_n, 1);
        step(1);
        recall_done = 1'b1;
        step(1);
        recall_done = 1'b0;
        check("R7 sel=0 keeps default", slave_addr, 8'hA2);
        step(N);
        check("R6 ready again", rdy_n, 0);

        finish_run();
    end
endmodule